// File: doc/BRIEF.md
# Converter Output Word Formatter

This block is the digital tail of a 10-bit sampling converter. On every rising edge of the sample clock it takes one raw quantiser result together with two range indicators: one marks a sample above full scale and one marks a sample below it. For each sample it produces a 10-bit output word and an out-of-range flag. The word is passed through in straight binary or converted to binary-reflected Gray code. Samples beyond either end of the range are clipped to the nearest end code.

Two static straps control the block. One strap selects the output code format. The other strap is active low and, when driven low, replaces the converted words with an alternating checkerboard test pattern. Both straps are registered at the pipeline input together with the sample. Because of this, a strap change applies to whole words, starting with the sample taken on the same edge.

Results leave through a launch register clocked on the falling edge of the sample clock. A word is therefore stable on the outputs across the rising edge at which downstream logic samples it. The latency from the sampling edge is fixed at four sample-clock cycles.

Top module: `adc_code_fmt`

## Requirements
- R1: While reset is asserted, and until the first sample reaches the outputs, `word_o` is 0000000000 and `range_err_o` is 0.
- R2: A sample taken at rising edge n is the value on the outputs at rising edge n+4. It is launched on the falling edge that follows rising edge n+3.
- R3: The outputs change only on falling edges of `clk`. Just after the falling edge that follows rising edge n+4, they already carry the sample taken at rising edge n+1.
- R4: With `gray_mode_i` = 0 and neither range indicator set, `word_o` equals the raw code (bit 0 is the LSB, bit 9 the MSB) and `range_err_o` is 0.
- R5: With `gray_mode_i` = 1, the word is the binary-reflected Gray form of the clipped binary code: the top bit is copied, and each lower bit i is binary bit i+1 XOR binary bit i. For example, 1111111111 becomes 1000000000 and 1000000000 becomes 1100000000.
- R6: With `above_fs_i` = 1, the raw code is ignored. The word is 1111111111 in binary mode or 1000000000 in Gray mode, and `range_err_o` is 1. If both range indicators are set, this condition wins.
- R7: With only `below_fs_i` = 1, the raw code is ignored. The word is 0000000000 in both formats and `range_err_o` is 1.
- R8: With `test_pat_n_i` = 0, the word comes from the checkerboard pattern and ignores code, range and format. Successive pattern words alternate between 0101010101 and 1010101010, and the first pattern word after reset is 0101010101. The pattern advances only on pattern words. `range_err_o` is 0 for pattern words.
- R9: Strap values are taken with the sample on the same rising edge. Changing a strap every cycle gives each word the format or pattern that was present when that word's sample was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; pipeline on rising edges, launch on falling edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_code_i | input | 10 | Raw quantiser result |
| above_fs_i | input | 1 | Sample is above the top of full scale |
| below_fs_i | input | 1 | Sample is below the bottom of full scale |
| gray_mode_i | input | 1 | 1 selects Gray output, 0 selects straight binary |
| test_pat_n_i | input | 1 | Active-low checkerboard pattern enable |
| word_o | output | 10 | Formatted output word |
| range_err_o | output | 1 | Out-of-range flag |

## Verification
A pipeline that is one stage too long or too short shifts every word by a cycle. The first changing input therefore shows up as a mismatch within five cycles, and the check made just after each falling edge separates a launch on the wrong edge from a wrong depth. A strap register that is not aligned with its sample shows up as a wrongly coded word on the first cycle after a mode toggle; the bench toggles the straps cycle by cycle to expose this. A pattern phase that is stuck or advances during converted data shows up on the first pattern word or on the second one, four cycles after the strap drops.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;

    // Range class of one incoming sample.
    typedef enum logic [1:0] {
        RNG_IN   = 2'd0,
        RNG_HIGH = 2'd1,
        RNG_LOW  = 2'd2
    } rng_e;

endpackage

// File: rtl/adc_fmt_sat.sv
// Clips a raw code to the end of scale its range class points at.
module adc_fmt_sat
    import adc_fmt_pkg::*;
#(
    parameter int unsigned CODE_W = 10
) (
    input  logic [CODE_W-1:0] code_i,
    input  rng_e              rng_i,
    output logic [CODE_W-1:0] code_o,
    output logic              flag_o
);

    always_comb begin
        code_o = code_i;
        flag_o = 1'b0;
        unique case (rng_i)
            RNG_HIGH: begin
                code_o = '1;
                flag_o = 1'b1;
            end
            RNG_LOW: begin
                code_o = '0;
                flag_o = 1'b1;
            end
            default: begin
                code_o = code_i;
                flag_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/adc_fmt_gray.sv
// Binary to binary-reflected Gray code.
module adc_fmt_gray #(
    parameter int unsigned CODE_W = 10
) (
    input  logic [CODE_W-1:0] bin_i,
    output logic [CODE_W-1:0] gray_o
);

    for (genvar i = 0; i < CODE_W; i++) begin : g_bit
        if (i == CODE_W - 1) begin : g_top
            assign gray_o[i] = bin_i[i];
        end else begin : g_low
            assign gray_o[i] = bin_i[i+1] ^ bin_i[i];
        end
    end

endmodule

// File: rtl/adc_fmt_launch.sv
// Falling-edge launch register: the word is stable across the next rising edge.
module adc_fmt_launch #(
    parameter int unsigned CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] word_i,
    input  logic              flag_i,
    output logic [CODE_W-1:0] word_o,
    output logic              flag_o
);

    typedef struct packed {
        logic [CODE_W-1:0] word;
        logic              flag;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d.word = word_i;
        out_d.flag = flag_i;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign word_o = out_q.word;
    assign flag_o = out_q.flag;

    // R3
    launch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_o == word_i) && (flag_o == flag_i))
        else $error("launch register not stable across rising edge");

endmodule

// File: rtl/adc_code_fmt.sv
module adc_code_fmt
    import adc_fmt_pkg::*;
#(
    parameter int unsigned CODE_W  = 10,
    parameter int unsigned LATENCY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] samp_code_i,
    input  logic              above_fs_i,
    input  logic              below_fs_i,
    input  logic              gray_mode_i,
    input  logic              test_pat_n_i,
    output logic [CODE_W-1:0] word_o,
    output logic              range_err_o
);

    // Three working stages (capture, clip, format) plus delay stages;
    // LATENCY must be at least 4.
    localparam int unsigned HOLD_N = LATENCY - 3;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        rng_e              rng;
        logic              gray;
        logic              pat;
    } cap_t;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              flag;
        logic              gray;
        logic              pat;
    } clip_t;

    typedef struct packed {
        logic [CODE_W-1:0] word;
        logic              flag;
    } fmt_t;

    typedef struct packed {
        cap_t                   cap;
        clip_t                  clip;
        fmt_t                   fmt;
        fmt_t [HOLD_N-1:0]      hold;
        logic                   phase;
    } state_t;

    state_t st_d, st_q;

    logic [CODE_W-1:0] sat_code;
    logic              sat_flag;
    logic [CODE_W-1:0] gray_code;
    logic [CODE_W-1:0] pat_word;

    adc_fmt_sat #(.CODE_W(CODE_W)) sat_i (
        .code_i (st_q.cap.code),
        .rng_i  (st_q.cap.rng),
        .code_o (sat_code),
        .flag_o (sat_flag)
    );

    adc_fmt_gray #(.CODE_W(CODE_W)) gray_i (
        .bin_i  (st_q.clip.code),
        .gray_o (gray_code)
    );

    always_comb begin
        for (int i = 0; i < CODE_W; i++) begin
            pat_word[i] = ((i % 2) == 0) ? ~st_q.phase : st_q.phase;
        end
    end

    always_comb begin
        st_d = st_q;

        // capture stage: sample and straps taken together
        st_d.cap.code = samp_code_i;
        if (above_fs_i) begin
            st_d.cap.rng = RNG_HIGH;
        end else if (below_fs_i) begin
            st_d.cap.rng = RNG_LOW;
        end else begin
            st_d.cap.rng = RNG_IN;
        end
        st_d.cap.gray = gray_mode_i;
        st_d.cap.pat  = ~test_pat_n_i;

        // clip stage
        st_d.clip.code = sat_code;
        st_d.clip.flag = sat_flag;
        st_d.clip.gray = st_q.cap.gray;
        st_d.clip.pat  = st_q.cap.pat;

        // format stage
        if (st_q.clip.pat) begin
            st_d.fmt.word = pat_word;
            st_d.fmt.flag = 1'b0;
            st_d.phase    = ~st_q.phase;
        end else begin
            st_d.fmt.word = st_q.clip.gray ? gray_code : st_q.clip.code;
            st_d.fmt.flag = st_q.clip.flag;
            st_d.phase    = st_q.phase;
        end

        // alignment delay
        st_d.hold[0] = st_q.fmt;
        for (int i = 1; i < HOLD_N; i++) begin
            st_d.hold[i] = st_q.hold[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    adc_fmt_launch #(.CODE_W(CODE_W)) launch_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .word_i (st_q.hold[HOLD_N-1].word),
        .flag_i (st_q.hold[HOLD_N-1].flag),
        .word_o (word_o),
        .flag_o (range_err_o)
    );

    // R6
    clip_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cap.rng == RNG_HIGH) |=> (st_q.clip.code == {CODE_W{1'b1}}) && st_q.clip.flag)
        else $error("above-scale sample not clipped to top");

    // R7
    clip_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cap.rng == RNG_LOW) |=> (st_q.clip.code == '0) && st_q.clip.flag)
        else $error("below-scale sample not clipped to bottom");

    // R5
    gray_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.clip.gray && !st_q.clip.pat) |=> ((^st_q.fmt.word) == $past(st_q.clip.code[0])))
        else $error("Gray word parity does not match binary LSB");

    // R8
    pat_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.clip.pat && $past(st_q.clip.pat)) |=> (st_q.fmt.word == ~$past(st_q.fmt.word)))
        else $error("consecutive pattern words not complementary");

    // R8
    pat_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.clip.pat |=> !st_q.fmt.flag)
        else $error("range flag set on a pattern word");

endmodule

// File: tb/adc_code_fmt_tb_top.sv
`timescale 1ns/1ps
module adc_code_fmt_tb_top;

    localparam int W = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] samp_code = '0;
    logic         above = 1'b0;
    logic         below = 1'b0;
    logic         gray = 1'b0;
    logic         pat_n = 1'b1;
    logic [W-1:0] word;
    logic         rerr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [W-1:0] w;
        logic         f;
        string        tag;
    } exp_t;

    exp_t q[$];
    bit   ph = 1'b0;

    always #2 clk = ~clk;

    adc_code_fmt dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .samp_code_i  (samp_code),
        .above_fs_i   (above),
        .below_fs_i   (below),
        .gray_mode_i  (gray),
        .test_pat_n_i (pat_n),
        .word_o       (word),
        .range_err_o  (rerr)
    );

    function automatic exp_t model(input logic [W-1:0] c, input logic hi, input logic lo,
                                   input logic g, input logic pn);
        exp_t e;
        int   b;
        if (!pn) begin
            e.w   = ph ? 10'b1010101010 : 10'b0101010101;
            e.f   = 1'b0;
            e.tag = "R8";
            ph    = ~ph;
            return e;
        end
        if (hi) begin
            b = 1023; e.f = 1'b1; e.tag = "R6";
        end else if (lo) begin
            b = 0; e.f = 1'b1; e.tag = "R7";
        end else begin
            b = int'(c); e.f = 1'b0; e.tag = g ? "R5" : "R4";
        end
        if (g) begin
            if (e.tag == "R4") e.tag = "R5";
            b = b ^ (b / 2);
        end
        e.w = W'(b);
        return e;
    endfunction

    always @(posedge clk) begin
        if (rst_n) q.push_back(model(samp_code, above, below, gray, pat_n));
    end

    task automatic chk(input string tag, input logic [W-1:0] aw, input logic af,
                       input logic [W-1:0] ew, input logic ef);
        checks++;
        if (aw !== ew || af !== ef) begin
            errors++;
            $display("FAIL %s word=%b flag=%b expected word=%b flag=%b at %0t",
                     tag, aw, af, ew, ef, $time);
        end
    endtask

    task automatic step(input logic [W-1:0] c, input logic hi, input logic lo,
                        input logic g, input logic pn);
        exp_t e;
        @(posedge clk);
        #1;
        e = q.pop_front();
        chk({"R2 ", e.tag}, word, rerr, e.w, e.f);
        samp_code = c; above = hi; below = lo; gray = g; pat_n = pn;
        #1.5;
        e = q[0];
        chk({"R3 ", e.tag}, word, rerr, e.w, e.f);
    endtask

    initial begin
        #800000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        exp_t z;
        z.w = '0; z.f = 1'b0; z.tag = "R1";
        repeat (4) q.push_back(z);
        repeat (5) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1", word, rerr, '0, 1'b0);
        rst_n = 1'b1;

        // R4 straight binary, in range
        step(10'h000, 0, 0, 0, 1);
        step(10'h001, 0, 0, 0, 1);
        step(10'h155, 0, 0, 0, 1);
        step(10'h200, 0, 0, 0, 1);
        step(10'h3FF, 0, 0, 0, 1);
        step(10'h1FF, 0, 0, 0, 1);
        for (int i = 0; i < 16; i++) step(W'($urandom), 0, 0, 0, 1);

        // R5 Gray, in range
        step(10'h3FF, 0, 0, 1, 1);
        step(10'h200, 0, 0, 1, 1);
        step(10'h1FF, 0, 0, 1, 1);
        step(10'h300, 0, 0, 1, 1);
        step(10'h001, 0, 0, 1, 1);
        for (int i = 0; i < 16; i++) step(W'($urandom), 0, 0, 1, 1);

        // R6 / R7 clipping, both formats, over wins
        step(10'h123, 1, 0, 0, 1);
        step(10'h123, 0, 1, 0, 1);
        step(10'h045, 1, 0, 1, 1);
        step(10'h3AB, 0, 1, 1, 1);
        step(10'h2F0, 1, 1, 0, 1);
        step(10'h2F0, 1, 1, 1, 1);

        // R8 checkerboard, first word after reset, ignores other inputs
        step(10'h3C3, 0, 0, 0, 0);
        step(10'h111, 1, 0, 1, 0);
        step(10'h222, 0, 1, 0, 0);
        step(10'h333, 1, 1, 1, 0);
        step(10'h0F0, 0, 0, 1, 1);
        step(10'h0F0, 0, 0, 1, 0);

        // R9 straps toggled every cycle
        for (int i = 0; i < 12; i++)
            step(10'h2B7, i % 3 == 2, 0, i[0], !(i % 4 == 1));

        for (int i = 0; i < 120; i++) begin
            int r;
            r = $urandom_range(0, 15);
            step(W'($urandom), r == 0, r == 1, $urandom_range(0, 1) == 1, r > 2);
        end

        for (int i = 0; i < 6; i++) step(10'h000, 0, 0, 0, 1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule